// File: doc/BRIEF.md
# RTC Update-Cycle and Interrupt Sequencer

This block runs the once-per-second update cycle of a real-time clock and tells software when the time bytes are safe to read. A 1 Hz tick from the prescaler opens an update window. The update-in-progress status goes high on the next clock and stays high for `WIN_TICKS` fast prescaler ticks. The calendar increment strobe fires only after `LEAD_TICKS` of those ticks have passed. As a result, software that sees the status low always has at least the lead interval before any time byte moves.

When the window closes, the block sets an update-ended flag and lowers the status bit on the same cycle. It also pulses a commit strobe that copies the counted time into the bytes software can see, unless the transfer-inhibit control is set. While inhibit is set, the increment strobe still fires, but the commit strobe and the update interrupt are held back.

A second generator raises a periodic flag on every 2^rate-th fast tick. Both flags clear when software reads the flag register. The interrupt request is the OR of each flag with its own enable. The calendar counters themselves sit outside this block.

Top module: `rtc_upd_irq_seq`

## Requirements
- R1: When idle, a `sec_tick` raises `uip` on the next clock. A `sec_tick` that arrives while `uip` is 1 is ignored and does not restart the window.
- R2: `time_incr` is a one-cycle pulse. It fires in the cycle of the `LEAD_TICKS`-th `div_tick` counted after `uip` rose, and it only occurs while `uip` is 1.
- R3: In the cycle of the `WIN_TICKS`-th `div_tick` after `uip` rose, the window ends. On the following clock `uip` is 0 and `upd_flag` is 1.
- R4: `time_commit` pulses in the same cycle as the window-ending `div_tick` only when `xfer_inhibit` is 0. It never pulses at any other time.
- R5: A `flags_rd` pulse clears `upd_flag` and `per_flag` on the next clock. If a flag's set event falls in the same cycle, the flag is set instead.
- R6: The fast ticks are counted from reset. With `per_rate` = r, where r is from 1 to 15, `per_flag` is set on each `div_tick` whose count index i (starting at 0) satisfies i mod 2^r = 2^r − 1. With r = 0, no periodic event occurs.
- R7: `irq` = (`upd_flag` AND `upd_ie` AND NOT `xfer_inhibit`) OR (`per_flag` AND `per_ie`), evaluated combinationally from the current flags and controls.
- R8: While reset is held, and until the first `sec_tick` or `div_tick`, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse at 1 Hz from the prescaler |
| div_tick | input | 1 | One-cycle pulse at the fast prescaler rate |
| upd_ie | input | 1 | Update interrupt enable |
| xfer_inhibit | input | 1 | Holds back the time transfer and the update interrupt |
| per_ie | input | 1 | Periodic interrupt enable |
| per_rate | input | 4 | Periodic rate select; 0 turns the periodic event off |
| flags_rd | input | 1 | Flag register read strobe; clears the flags |
| uip | output | 1 | Update in progress |
| time_incr | output | 1 | Calendar increment strobe |
| time_commit | output | 1 | Transfer of counted time to the visible bytes |
| upd_flag | output | 1 | Update-ended flag |
| per_flag | output | 1 | Periodic flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends a `sec_tick` in the middle of a window. A design that restarts the window on it would stretch `uip` and fire a second increment. It places a flag read in the exact cycle the window ends, where a clear that wins over the set would lose the update-ended event. It runs windows with inhibit set, where a faulty design would still commit or still interrupt. It also steps the periodic rate between 0, 1 and 3, so a mask that is off by one bit produces events on the wrong ticks.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_BUSY = 1'b1
  } win_st_e;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_upd_window.sv
module rtc_upd_window
  import rtc_upd_pkg::*;
#(
  parameter int LEAD_TICKS = 1,
  parameter int WIN_TICKS  = 8,
  localparam int CW = $clog2(WIN_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic div_tick,
  input  logic xfer_inhibit,
  output logic busy,
  output logic incr,
  output logic done,
  output logic commit
);
  localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_TICKS - 1);
  localparam logic [CW-1:0] WIN_LAST  = CW'(WIN_TICKS - 1);

  win_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign busy   = (st_q == WIN_BUSY);
  assign incr   = busy && div_tick && (cnt_q == LEAD_LAST);
  assign done   = busy && div_tick && (cnt_q == WIN_LAST);
  assign commit = done && !xfer_inhibit;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      WIN_IDLE: begin
        if (sec_tick) begin
          st_d   = WIN_BUSY;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      WIN_BUSY: begin
        if (div_tick) begin
          cnt_en = 1'b1;
          if (cnt_q == WIN_LAST) begin
            st_d  = WIN_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WIN_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_uip_from_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sec_tick));
  assert_incr_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    incr |-> busy);
  assert_close_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  assert_no_commit_inhibit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_inhibit |-> !commit);
endmodule

// File: rtl/rtc_per_gen.sv
module rtc_per_gen #(
  parameter int PCNT_W = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_tick,
  input  logic [RATE_W-1:0] rate,
  output logic              per_evt
);
  logic [PCNT_W-1:0] pcnt_q, pcnt_d, mask;

  assign mask    = ({{(PCNT_W-1){1'b0}}, 1'b1} << rate) - 1'b1;
  assign per_evt = div_tick && (rate != '0) && ((pcnt_q & mask) == mask);
  assign pcnt_d  = pcnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt_q <= '0;
    else if (div_tick) pcnt_q <= pcnt_d;
  end

  assert_evt_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |-> (div_tick && rate != '0));
endmodule

// File: rtl/rtc_upd_irq_seq.sv
module rtc_upd_irq_seq #(
  parameter int LEAD_TICKS = 1,
  parameter int WIN_TICKS  = 8,
  parameter int PCNT_W     = 15,
  parameter int RATE_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              div_tick,
  input  logic              upd_ie,
  input  logic              xfer_inhibit,
  input  logic              per_ie,
  input  logic [RATE_W-1:0] per_rate,
  input  logic              flags_rd,
  output logic              uip,
  output logic              time_incr,
  output logic              time_commit,
  output logic              upd_flag,
  output logic              per_flag,
  output logic              irq
);
  logic rst_i_n, win_done, per_evt;
  logic uf_q, uf_d, pf_q, pf_d;

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  rtc_upd_window #(.LEAD_TICKS(LEAD_TICKS), .WIN_TICKS(WIN_TICKS)) u_win (
    .clk(clk), .rst_n(rst_i_n), .sec_tick(sec_tick), .div_tick(div_tick),
    .xfer_inhibit(xfer_inhibit), .busy(uip), .incr(time_incr),
    .done(win_done), .commit(time_commit)
  );

  rtc_per_gen #(.PCNT_W(PCNT_W), .RATE_W(RATE_W)) u_per (
    .clk(clk), .rst_n(rst_i_n), .div_tick(div_tick), .rate(per_rate),
    .per_evt(per_evt)
  );

  always_comb begin
    uf_d = uf_q;
    pf_d = pf_q;
    if (flags_rd) begin
      uf_d = 1'b0;
      pf_d = 1'b0;
    end
    if (win_done) uf_d = 1'b1;
    if (per_evt)  pf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      uf_q <= 1'b0;
      pf_q <= 1'b0;
    end else begin
      uf_q <= uf_d;
      pf_q <= pf_d;
    end
  end

  assign upd_flag = uf_q;
  assign per_flag = pf_q;
  assign irq = (uf_q && upd_ie && !xfer_inhibit) || (pf_q && per_ie);

  assert_flag_with_close_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(uip) |-> upd_flag);
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (flags_rd && !win_done) |=> !upd_flag);
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq && !per_ie) |-> (upd_ie && !xfer_inhibit));
endmodule

// File: tb/rtc_upd_irq_seq_test.sv
`timescale 1ns/100ps
module rtc_upd_irq_seq_test;
  localparam int LEAD = 1;
  localparam int WIN  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic sec_tick, div_tick, upd_ie, xfer_inhibit, per_ie, flags_rd;
  logic [3:0] per_rate;
  logic uip, time_incr, time_commit, upd_flag, per_flag, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // model state
  bit m_busy = 0;
  int m_cnt = 0;
  bit m_uf = 0;
  bit m_pf = 0;
  int m_pcnt = 0;

  always #2.5 clk = ~clk;

  rtc_upd_irq_seq #(.LEAD_TICKS(LEAD), .WIN_TICKS(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .div_tick(div_tick),
    .upd_ie(upd_ie), .xfer_inhibit(xfer_inhibit), .per_ie(per_ie),
    .per_rate(per_rate), .flags_rd(flags_rd), .uip(uip),
    .time_incr(time_incr), .time_commit(time_commit),
    .upd_flag(upd_flag), .per_flag(per_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit s, input bit d, input bit r);
    bit e_incr, e_done, e_pev;
    int per;
    sec_tick = s; div_tick = d; flags_rd = r;
    #1;
    e_incr = m_busy && d && (m_cnt == LEAD-1);
    e_done = m_busy && d && (m_cnt == WIN-1);
    per = 1 << per_rate;
    e_pev = d && (per_rate != 0) && ((m_pcnt % per) == per - 1);
    chk("R1 uip", uip, m_busy);
    chk("R2 time_incr", time_incr, e_incr);
    chk("R4 time_commit", time_commit, e_done && !xfer_inhibit);
    chk("R3 upd_flag", upd_flag, m_uf);
    chk("R6 per_flag", per_flag, m_pf);
    chk("R7 irq", irq, (m_uf && upd_ie && !xfer_inhibit) || (m_pf && per_ie));
    // next model state
    if (!m_busy && s) begin m_busy = 1; m_cnt = 0; end
    else if (m_busy && d) begin
      if (m_cnt == WIN-1) begin m_busy = 0; m_cnt = 0; end
      else m_cnt++;
    end
    if (e_done) m_uf = 1; else if (r) m_uf = 0;  // R5 set wins
    if (e_pev)  m_pf = 1; else if (r) m_pf = 0;
    if (d) m_pcnt = (m_pcnt + 1) % 32768;
    @(posedge clk);
    @(negedge clk);
  endtask

  // one window: sec at i==0, div every 3rd cycle, optional extra sec and read
  task automatic window(input int n, input int sec2_at, input int rd_at);
    for (int i = 0; i < n; i++)
      cyc(i == 0 || i == sec2_at, (i % 3) == 2, i == rd_at);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sec_tick = 0; div_tick = 0; flags_rd = 0;
    upd_ie = 1; xfer_inhibit = 0; per_ie = 0; per_rate = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: outputs idle in reset
    chk("R8 uip", uip, 0); chk("R8 upd_flag", upd_flag, 0);
    chk("R8 per_flag", per_flag, 0); chk("R8 irq", irq, 0);
    rst_n = 1;
    repeat (4) cyc(0, 0, 0);
    // normal window, interrupt on, then read clears (R5)
    window(30, -1, -1);
    window(6, -1, 2);
    // second sec_tick mid-window ignored (R1)
    window(30, 7, -1);
    // read in the exact cycle the window ends: set wins (R5)
    window(30, -1, 23);
    window(4, -1, 1);
    // inhibit: no commit, no update irq (R4, R7)
    xfer_inhibit = 1;
    window(30, -1, -1);
    xfer_inhibit = 0;
    cyc(0, 0, 0);
    upd_ie = 0;
    window(30, -1, 28);
    // periodic rates (R6)
    per_ie = 1; per_rate = 1;
    window(30, -1, 10);
    per_rate = 3;
    for (int k = 0; k < 60; k++) cyc(0, (k % 2) == 1, (k % 9) == 8);
    per_rate = 0;
    for (int k = 0; k < 20; k++) cyc(0, (k % 2) == 1, k == 3);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule